// File: doc/BRIEF.md
# One-Wire ROM Command Layer

This block sits between a one-wire bit engine and a device's function layer, and it handles network addressing after every bus reset. The bit engine hands it received bits and reset events. It also takes from the block the bits to be driven in read slots. The block collects an 8-bit ROM command, least significant bit first, and carries it out against a 64-bit identity. The identity is built from a family-code parameter and a serial-number parameter, and a check byte is appended. The block holds a resume flag and an overdrive flag. The overdrive flag tells the bit engine which slot timing to use.

A serial CRC-8 unit (x^8 + x^5 + x^4 + 1, register cleared on every bus reset) runs over the identity one bit at a time as the identity is used. For the first 56 bits it takes the parameter bits. For the last eight it takes its own low register bit, so that the unit both produces the check byte and ends at zero. When addressing succeeds, the next received byte goes up to the function layer as a function command. After that, the block waits for the next bus reset.

Three streams use a valid/ready handshake. On received bits (`rx_*`), a bit is consumed only in a cycle where both valid and ready are high, and the engine must hold `rx_bit` while it waits. On transmitted bits (`tx_*`), the block holds `tx_bit` until the engine asserts `tx_ready`. On the function byte (`fn_*`), the block holds the code until the function layer accepts it, and it takes no further bits while the byte is pending. A bus reset ends any transfer in progress.

Top module: `onewire_rom_layer`

## Requirements
- R1: After `rst_n` the block asserts neither `rx_ready`, `tx_valid` nor `fn_valid`, and both flags read 0. It stays this way until the first bus reset. After any bus reset it asserts `rx_ready` and waits for a command byte.
- R2: A command byte is received LSB first. The codes are 33h read, 55h match, F0h search, CCh skip, A5h resume, 3Ch overdrive-skip and 69h overdrive-match.
- R3: Read sends all 64 identity bits LSB first: family code 3Ah in bits 7:0, the serial number in bits 55:8 and the check byte in bits 63:56. It then sets the resume flag and waits for a function byte.
- R4: The check byte is the CRC-8 (x^8+x^5+x^4+1, start value zero, LSB first) of identity bits 55:0. A CRC over all 64 sent bits is zero.
- R5: Match takes 64 bits and compares each with the identity. On any mismatch it clears the resume flag and stops accepting bits until a bus reset. If all 64 bits agree, it sets the resume flag and waits for a function byte.
- R6: Search sends each identity bit, then its complement, and then reads the master's bit. If the master's bit differs, the resume flag is cleared and the block goes idle until a bus reset. When all 64 bits agree, the resume flag is set and the function phase follows.
- R7: Skip clears the resume flag and enters the function phase. Resume enters the function phase only if the resume flag is 1. Otherwise the block goes idle until a bus reset.
- R8: Overdrive-skip and overdrive-match set the overdrive flag when their command byte completes. Overdrive-skip also clears the resume flag. Overdrive-match then works as match.
- R9: A bus reset with `bus_rst_std`=1 clears the overdrive flag. A bus reset with `bus_rst_std`=0 leaves it unchanged.
- R10: Any other command code makes the block idle until a bus reset, with `rx_ready` and `tx_valid` both low.
- R11: The function byte is presented on `fn_code` with `fn_valid`, and both are held until `fn_ready`. `fn_known` is 1 exactly for F5h and 5Ah. After the byte is accepted, no more bits are taken until a bus reset.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_bit` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: the bit engine saw a bus reset |
| bus_rst_std | input | 1 | Qualifies bus_rst: 1 for a standard-length reset pulse |
| rx_valid | input | 1 | A received bit is offered |
| rx_ready | output | 1 | Block can consume a received bit |
| rx_bit | input | 1 | Received bit value |
| tx_valid | output | 1 | Block offers a bit for the next read slot |
| tx_ready | input | 1 | Bit engine consumes tx_bit |
| tx_bit | output | 1 | Bit to send |
| fn_valid | output | 1 | A function command byte is presented |
| fn_ready | input | 1 | Function layer accepts the byte |
| fn_code | output | 8 | Function command byte |
| fn_known | output | 1 | fn_code is one of the two valid function codes |
| od_mode | output | 1 | Overdrive flag |
| resume_flag | output | 1 | Resume flag |

## Verification
The assertions assume that `bus_rst` arrives as a single-cycle pulse. They also assume that the upstream engine keeps its offered bit stable until the handshake completes. The bench drives every input on the falling clock edge and drops `rx_valid`, `tx_ready` and `bus_rst` after exactly one rising edge. In this way every handshake completes once, and `bus_rst_std` is meaningful only in the reset cycle. The bench also holds `tx_ready` low for several cycles to check that the transmit bit stays held. It raises `fn_ready` only after it has seen `fn_valid` held.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

  localparam int ID_BITS   = 64;
  localparam int BODY_BITS = 56;

  localparam logic [7:0] CMD_READ    = 8'h33;
  localparam logic [7:0] CMD_MATCH   = 8'h55;
  localparam logic [7:0] CMD_SEARCH  = 8'hF0;
  localparam logic [7:0] CMD_SKIP    = 8'hCC;
  localparam logic [7:0] CMD_RESUME  = 8'hA5;
  localparam logic [7:0] CMD_OD_SKIP = 8'h3C;
  localparam logic [7:0] CMD_OD_MTCH = 8'h69;

  localparam logic [7:0] FN_PIN_RD = 8'hF5;
  localparam logic [7:0] FN_PIN_WR = 8'h5A;

  // reflected form of x^8 + x^5 + x^4 + 1
  localparam logic [7:0] CRC_POLY_R = 8'h8C;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_S_TRUE,
    ST_S_COMP,
    ST_S_PICK,
    ST_FN,
    ST_FN_OUT,
    ST_DONE,
    ST_HALT
  } rom_state_e;

  function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc8_next = (c >> 1) ^ (fb ? CRC_POLY_R : 8'h00);
  endfunction

endpackage

// File: rtl/owrom_crc8.sv
module owrom_crc8
  import owrom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic       din,
  output logic [7:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= '0;
    else if (clr)  crc <= '0;
    else if (step) crc <= crc8_next(crc, din);
  end

endmodule

// File: rtl/owrom_shift_in.sv
module owrom_shift_in #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);

  // LSB-first: newest bit enters at the top, oldest drifts to bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= {din, q[W-1:1]};
  end

endmodule

// File: rtl/owrom_fsm.sv
module owrom_fsm
  import owrom_pkg::*;
#(
  parameter logic [BODY_BITS-1:0] ID_BODY = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       bus_rst_std,
  input  logic       rx_valid,
  input  logic       rx_bit,
  output logic       rx_ready,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic       tx_bit,
  input  logic       fn_ready,
  output logic       fn_valid,
  output logic [7:0] fn_code,
  output logic       fn_known,
  output logic       od_mode,
  output logic       resume_flag,
  input  logic [7:0] sh_q,
  output logic       sh_en,
  input  logic [7:0] crc_q,
  output logic       crc_step,
  output logic       crc_clr,
  output logic       crc_din
);

  localparam int CW = $clog2(ID_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(ID_BITS - 1);
  localparam logic [CW-1:0] LAST_BYTE_BIT = CW'(7);
  localparam logic [ID_BITS-1:0] BODY_EXT = {{(ID_BITS-BODY_BITS){1'b0}}, ID_BODY};

  rom_state_e    st;
  logic [CW-1:0] cnt;
  logic          id_bit;
  logic          rx_fire, tx_fire;
  logic [7:0]    byte_nxt;
  logic          last;

  assign id_bit   = (cnt < CW'(BODY_BITS)) ? BODY_EXT[cnt] : crc_q[0];
  assign rx_ready = (st == ST_CMD) || (st == ST_MATCH) || (st == ST_S_PICK) || (st == ST_FN);
  assign tx_valid = (st == ST_READ) || (st == ST_S_TRUE) || (st == ST_S_COMP);
  assign tx_bit   = (st == ST_S_COMP) ? ~id_bit : id_bit;
  assign rx_fire  = rx_valid && rx_ready && !bus_rst;
  assign tx_fire  = tx_valid && tx_ready && !bus_rst;
  assign byte_nxt = {rx_bit, sh_q[7:1]};
  assign last     = (cnt == LAST_BIT);
  assign sh_en    = rx_fire;
  assign fn_known = (fn_code == FN_PIN_RD) || (fn_code == FN_PIN_WR);
  assign crc_clr  = bus_rst;
  assign crc_din  = id_bit;

  // the CRC advances whenever an identity position is finished
  always_comb begin
    crc_step = 1'b0;
    unique case (st)
      ST_READ:   crc_step = tx_fire;
      ST_MATCH:  crc_step = rx_fire && (rx_bit == id_bit);
      ST_S_PICK: crc_step = rx_fire && (rx_bit == id_bit);
      default:   crc_step = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_WAIT;
      cnt         <= '0;
      od_mode     <= 1'b0;
      resume_flag <= 1'b0;
      fn_valid    <= 1'b0;
      fn_code     <= '0;
    end else if (bus_rst) begin
      st       <= ST_CMD;
      cnt      <= '0;
      fn_valid <= 1'b0;
      if (bus_rst_std) od_mode <= 1'b0;
    end else begin
      unique case (st)
        ST_CMD: if (rx_fire) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BYTE_BIT) begin
            cnt <= '0;
            case (byte_nxt)
              CMD_READ:    st <= ST_READ;
              CMD_MATCH:   st <= ST_MATCH;
              CMD_SEARCH:  st <= ST_S_TRUE;
              CMD_SKIP:    begin resume_flag <= 1'b0; st <= ST_FN; end
              CMD_RESUME:  st <= resume_flag ? ST_FN : ST_HALT;
              CMD_OD_SKIP: begin od_mode <= 1'b1; resume_flag <= 1'b0; st <= ST_FN; end
              CMD_OD_MTCH: begin od_mode <= 1'b1; st <= ST_MATCH; end
              default:     st <= ST_HALT;
            endcase
          end
        end
        ST_READ: if (tx_fire) begin
          if (last) begin
            cnt <= '0; resume_flag <= 1'b1; st <= ST_FN;
          end else cnt <= cnt + 1'b1;
        end
        ST_MATCH: if (rx_fire) begin
          if (rx_bit != id_bit) begin
            resume_flag <= 1'b0; st <= ST_HALT;
          end else if (last) begin
            cnt <= '0; resume_flag <= 1'b1; st <= ST_FN;
          end else cnt <= cnt + 1'b1;
        end
        ST_S_TRUE: if (tx_fire) st <= ST_S_COMP;
        ST_S_COMP: if (tx_fire) st <= ST_S_PICK;
        ST_S_PICK: if (rx_fire) begin
          if (rx_bit != id_bit) begin
            resume_flag <= 1'b0; st <= ST_HALT;
          end else if (last) begin
            cnt <= '0; resume_flag <= 1'b1; st <= ST_FN;
          end else begin
            cnt <= cnt + 1'b1; st <= ST_S_TRUE;
          end
        end
        ST_FN: if (rx_fire) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BYTE_BIT) begin
            cnt <= '0; fn_code <= byte_nxt; fn_valid <= 1'b1; st <= ST_FN_OUT;
          end
        end
        ST_FN_OUT: if (fn_ready) begin
          fn_valid <= 1'b0; st <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  // R12: offered transmit bit is held until consumed
  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_rst) |=> (tx_valid && $stable(tx_bit)));

  // R11: function byte held until accepted
  assert_fn_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_valid && !fn_ready && !bus_rst) |=> (fn_valid && $stable(fn_code)));

  // R9: standard-length reset drops overdrive, overdrive reset keeps it
  assert_od_std_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && bus_rst_std) |=> !od_mode);
  assert_od_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !bus_rst_std && od_mode) |=> od_mode);

  // R1: every bus reset opens a fresh command phase
  assert_cmd_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (rx_ready && !tx_valid && !fn_valid));

  // R4: after the final identity bit is sent the CRC register is clear
  assert_crc_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && tx_fire && last) |=> (crc_q == 8'h00));

  // R10: never offer and accept bits at once
  assert_one_direction_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

endmodule

// File: rtl/onewire_rom_layer.sv
module onewire_rom_layer
  import owrom_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h3A,
  parameter logic [47:0] SERIAL_NUM  = 48'h0000_5A17_C0DE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       bus_rst_std,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic       rx_bit,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic       tx_bit,
  output logic       fn_valid,
  input  logic       fn_ready,
  output logic [7:0] fn_code,
  output logic       fn_known,
  output logic       od_mode,
  output logic       resume_flag
);

  localparam logic [BODY_BITS-1:0] BODY = {SERIAL_NUM, FAMILY_CODE};

  logic [7:0] sh_q;
  logic       sh_en;
  logic [7:0] crc_q;
  logic       crc_step, crc_clr, crc_din;

  owrom_shift_in #(.W(8)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (sh_en),
    .din   (rx_bit),
    .q     (sh_q)
  );

  owrom_crc8 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .step  (crc_step),
    .din   (crc_din),
    .crc   (crc_q)
  );

  owrom_fsm #(.ID_BODY(BODY)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst     (bus_rst),
    .bus_rst_std (bus_rst_std),
    .rx_valid    (rx_valid),
    .rx_bit      (rx_bit),
    .rx_ready    (rx_ready),
    .tx_ready    (tx_ready),
    .tx_valid    (tx_valid),
    .tx_bit      (tx_bit),
    .fn_ready    (fn_ready),
    .fn_valid    (fn_valid),
    .fn_code     (fn_code),
    .fn_known    (fn_known),
    .od_mode     (od_mode),
    .resume_flag (resume_flag),
    .sh_q        (sh_q),
    .sh_en       (sh_en),
    .crc_q       (crc_q),
    .crc_step    (crc_step),
    .crc_clr     (crc_clr),
    .crc_din     (crc_din)
  );

endmodule

// File: tb/tb_onewire_rom_layer.sv
`timescale 1ns/1ps
module tb_onewire_rom_layer;

  localparam logic [47:0] TB_SERIAL = 48'h00A1_B2C3_D4E5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0, bus_rst_std = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, rx_ready;
  logic tx_valid, tx_ready = 1'b0, tx_bit;
  logic fn_valid, fn_ready = 1'b0, fn_known;
  logic [7:0] fn_code;
  logic od_mode, resume_flag;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_id;

  always #10 clk = ~clk;

  onewire_rom_layer #(.FAMILY_CODE(8'h3A), .SERIAL_NUM(TB_SERIAL)) dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_rst_std(bus_rst_std),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .fn_valid(fn_valid), .fn_ready(fn_ready), .fn_code(fn_code), .fn_known(fn_known),
    .od_mode(od_mode), .resume_flag(resume_flag)
  );

  function automatic logic [7:0] ref_crc(input logic [63:0] v, input int nbits);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      logic fb = c[0] ^ v[i];
      c = (c >> 1) ^ (fb ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_reset(input logic std);
    @(negedge clk); bus_rst = 1'b1; bus_rst_std = std;
    @(negedge clk); bus_rst = 1'b0; bus_rst_std = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    int w = 0;
    while (!rx_ready && w < 20) begin @(negedge clk); w++; end
    rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic get_bit(output logic b);
    int w = 0;
    while (!tx_valid && w < 20) begin @(negedge clk); w++; end
    b = tx_bit; tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic take_fn(input logic [7:0] exp_code, input logic exp_known, input string tag);
    int w = 0;
    while (!fn_valid && w < 20) begin @(negedge clk); w++; end
    chk(fn_valid && fn_code == exp_code, {tag, " fn_code"}, fn_code, exp_code);
    chk(fn_known == exp_known, {tag, " fn_known"}, fn_known, exp_known);
    repeat (3) @(negedge clk);
    chk(fn_valid && fn_code == exp_code, {tag, " fn hold"}, fn_valid, 1);
    fn_ready = 1'b1; @(negedge clk); fn_ready = 1'b0;
    chk(!fn_valid && !rx_ready, {tag, " done after handoff"}, {fn_valid, rx_ready}, 0);
  endtask

  task automatic check_idle(input string tag);
    repeat (3) @(negedge clk);
    chk(!rx_ready && !tx_valid, tag, {rx_ready, tx_valid}, 0);
  endtask

  task automatic t_reset_state;
    chk(!rx_ready && !tx_valid && !fn_valid, "R1 idle after rst_n", {rx_ready, tx_valid, fn_valid}, 0);
    chk(!od_mode && !resume_flag, "R1 flags clear", {od_mode, resume_flag}, 0);
    bus_reset(1'b1);
    chk(rx_ready && !tx_valid, "R1 ready after bus reset", rx_ready, 1);
  endtask

  task automatic t_read;
    logic [63:0] got;
    logic b, b0;
    bus_reset(1'b1);
    send_byte(8'h33);
    while (!tx_valid) @(negedge clk);
    b0 = tx_bit;
    repeat (3) @(negedge clk);
    chk(tx_valid && tx_bit == b0, "R12 tx held without ready", tx_bit, b0);
    for (int i = 0; i < 64; i++) begin get_bit(b); got[i] = b; end
    chk(got == exp_id, "R3 read identity", got, exp_id);
    chk(got[7:0] == 8'h3A, "R3 family byte", got[7:0], 8'h3A);
    chk(ref_crc(got, 64) == 8'h00, "R4 crc over 64 bits zero", ref_crc(got, 64), 0);
    chk(resume_flag == 1'b1, "R3 resume set", resume_flag, 1);
    send_byte(8'hF5);
    take_fn(8'hF5, 1'b1, "R11 read-pins");
  endtask

  task automatic t_match(input logic [7:0] cmd, input int flip, input string tag);
    logic [63:0] v = exp_id;
    if (flip >= 0) v[flip] = ~v[flip];
    bus_reset(1'b1);
    send_byte(cmd);
    for (int i = 0; i < 64; i++) begin
      if (flip >= 0 && i > flip) break;
      send_bit(v[i]);
    end
    if (flip >= 0) begin
      check_idle({tag, " halt on mismatch"});
      chk(resume_flag == 1'b0, {tag, " resume cleared"}, resume_flag, 0);
    end else begin
      chk(resume_flag == 1'b1, {tag, " resume set"}, resume_flag, 1);
      send_byte(8'h5A);
      take_fn(8'h5A, 1'b1, {tag, " write-pins"});
    end
  endtask

  task automatic t_search(input int lose);
    logic t, c;
    bus_reset(1'b1);
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      get_bit(t); get_bit(c);
      if (i < 3 || i > 60) begin
        chk(t == exp_id[i] && c == ~exp_id[i], "R6 search bit pair", {t, c}, {exp_id[i], ~exp_id[i]});
      end
      if (i == lose) begin send_bit(~t); break; end
      send_bit(t);
    end
    if (lose >= 0) begin
      check_idle("R6 search loser idle");
      chk(resume_flag == 1'b0, "R6 loser resume clear", resume_flag, 0);
    end else begin
      chk(resume_flag == 1'b1, "R6 winner resume set", resume_flag, 1);
      chk(rx_ready && !tx_valid, "R6 winner in function phase", rx_ready, 1);
    end
  endtask

  task automatic t_skip_resume;
    bus_reset(1'b1);
    send_byte(8'hCC);
    chk(resume_flag == 1'b0 && rx_ready, "R7 skip clears resume", resume_flag, 0);
    send_byte(8'h11);
    take_fn(8'h11, 1'b0, "R11 unknown function");
    bus_reset(1'b1);
    send_byte(8'hA5);
    check_idle("R7 resume without flag halts");
    t_match(8'h55, -1, "R5 match ok");
    bus_reset(1'b1);
    send_byte(8'hA5);
    chk(rx_ready && !tx_valid, "R7 resume with flag selects", rx_ready, 1);
  endtask

  task automatic t_overdrive;
    bus_reset(1'b1);
    chk(od_mode == 1'b0, "R9 std reset od clear", od_mode, 0);
    send_byte(8'h3C);
    chk(od_mode == 1'b1 && resume_flag == 1'b0, "R8 od-skip sets od", {od_mode, resume_flag}, 2'b10);
    bus_reset(1'b0);
    chk(od_mode == 1'b1, "R9 overdrive reset keeps od", od_mode, 1);
    bus_reset(1'b1);
    chk(od_mode == 1'b0, "R9 std reset clears od", od_mode, 0);
    t_match(8'h69, -1, "R8 od-match");
    chk(od_mode == 1'b1, "R8 od-match sets od", od_mode, 1);
    bus_reset(1'b1);
  endtask

  task automatic t_unknown;
    bus_reset(1'b1);
    send_byte(8'h00);
    check_idle("R10 unknown command halts");
    send_bit(1'b1);
    chk(!fn_valid && !tx_valid, "R10 no output while halted", {fn_valid, tx_valid}, 0);
    bus_reset(1'b1);
    chk(rx_ready, "R2 new command phase after halt", rx_ready, 1);
  endtask

  initial begin
    exp_id = {8'h00, TB_SERIAL, 8'h3A};
    exp_id[63:56] = ref_crc(exp_id, 56);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read();
    t_match(8'h55, -1, "R5 match ok");
    t_match(8'h55, 10, "R5 match fail");
    t_match(8'h55, 60, "R5 match fail in check byte");
    t_skip_resume();
    t_search(-1);
    t_search(5);
    t_overdrive();
    t_unknown();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule